// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block sits on the master side of a two-wire serial bus. Its job is to bring a memory slave back to idle when the master was reset partway through a transfer, for example by a supply dip. Such a slave has no reset pin of its own. It may still be holding SDA low, either to acknowledge or to shift out a zero data bit. While it does so, the master cannot send any command.

When a request arrives, or automatically after reset when enabled, the sequencer drives the bus through open-drain pull-down enables in a fixed pattern:

- a start condition;
- nine dummy SCL pulses with SDA released;
- a second start condition;
- a stop condition.

The second start is required. Without it, a stop that follows the clock train could be taken by the slave as the end of a write, and the slave would begin a write cycle.

Every phase of the pattern lasts one half-period of SCL. The half-period length comes from a divider input that is sampled at launch. A write-protect output stays high for the whole recovery. At the end, a one-cycle done pulse is raised. The SDA level sampled during the final phase is reported, and a low reading flags that the slave is still stuck.

Top module: `bus_unjam_seq`

## Requirements
- R1: While reset is active and after its release with no launch, both pull-down enables, busy, done, write-protect and the stuck flag are all 0.
- R2: A launch sampled at a clock edge while idle makes busy 1 from that edge for exactly 25·H cycles, where H is the half-period length of R7. Busy is 0 afterwards.
- R3: The first event is an opening start: SCL released and SDA released for H cycles, then SDA pulled low with SCL released for H cycles. SCL is not pulled low before SDA has been pulled low.
- R4: After the opening start, SCL is pulled low with SDA held low for H cycles. Then exactly 9 dummy pulses follow, each being H cycles with SCL low and H cycles with SCL high, with SDA released throughout.
- R5: Right after the high half of the 9th dummy pulse, SDA is pulled low while SCL stays released, for H cycles. This is the second start condition, and no SCL low phase comes between it and the 9th pulse.
- R6: The run ends with the stop: H cycles with SCL low and SDA low, then H cycles with SCL released and SDA low, then H cycles with both released. The SDA enable never changes in the same cycle as the SCL enable, and both are released when the run ends.
- R7: H equals the divider input sampled at launch, with a value of 0 treated as 1. Every phase lasts exactly H cycles.
- R8: Write-protect is 1 in every cycle in which busy is 1.
- R9: Done is 1 for exactly one cycle, the first cycle after busy falls.
- R10: The stuck flag takes the inverse of the SDA input as sampled at the last cycle of the final phase. It holds that value until the next launch, which clears it.
- R11: A request that arrives while busy neither restarts nor extends the run, and no second run follows it.
- R12: With the auto-start parameter set, a run launches at the first clock edge after reset is released, with no request input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick_i | input | 1 | Recovery request, sampled while idle |
| half_div_i | input | DIV_W | SCL half-period in clock cycles (0 acts as 1) |
| sda_in_i | input | 1 | Sampled level of the SDA line |
| scl_pull_o | output | 1 | Pull-down enable for SCL (1 drives low) |
| sda_pull_o | output | 1 | Pull-down enable for SDA (1 drives low) |
| wp_o | output | 1 | Write-protect, high during recovery |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| stuck_o | output | 1 | SDA read low at the end of the last run |

## Verification
The bench sweeps the divider over 0 through 4 and compares every cycle of each run against an expected line pattern. That pattern is computed from the cycle index, so an off-by-one in the pulse count or a divider that mishandles 0 shows up as a shifted or missing phase. It counts start conditions and SCL rising edges on the driven levels. A design that skipped the second start, or added a tenth dummy pulse, would report three starts, one start, or eleven rises. A slave model holds SDA low for a chosen number of SCL rises. Releasing at the 9th or 10th rise must give a clean result and holding longer must set the stuck flag, so a design sampling SDA one phase early or late gets the flag wrong at that boundary. Requests injected mid-run check that the done pulse arrives on the unchanged cycle and that no second run follows.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

  // One phase per SCL half-period; IDLE leaves both lines released.
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_PRE,
    PH_OPEN,
    PH_OPEN_HOLD,
    PH_DUMMY_LO,
    PH_DUMMY_HI,
    PH_REOPEN,
    PH_REOPEN_HOLD,
    PH_CLOSE_SU,
    PH_CLOSE
  } phase_t;

  typedef struct packed {
    logic scl_up;
    logic sda_up;
  } lines_t;

  // Line levels the master leaves on the bus during each phase.
  function automatic lines_t phase_lines(input phase_t p);
    lines_t l;
    case (p)
      PH_OPEN:        l = '{scl_up: 1'b1, sda_up: 1'b0};
      PH_OPEN_HOLD:   l = '{scl_up: 1'b0, sda_up: 1'b0};
      PH_DUMMY_LO:    l = '{scl_up: 1'b0, sda_up: 1'b1};
      PH_DUMMY_HI:    l = '{scl_up: 1'b1, sda_up: 1'b1};
      PH_REOPEN:      l = '{scl_up: 1'b1, sda_up: 1'b0};
      PH_REOPEN_HOLD: l = '{scl_up: 1'b0, sda_up: 1'b0};
      PH_CLOSE_SU:    l = '{scl_up: 1'b1, sda_up: 1'b0};
      default:        l = '{scl_up: 1'b1, sda_up: 1'b1};
    endcase
    return l;
  endfunction

  // Half-period length in clock cycles; a zero setting means one cycle.
  function automatic logic [31:0] half_cycles(input logic [31:0] d);
    return (d == 32'd0) ? 32'd1 : d;
  endfunction

endpackage

// File: rtl/busrec_pacer.sv
module busrec_pacer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  import busrec_pkg::*;

  logic [DIV_W-1:0] h_q;
  logic [DIV_W-1:0] cnt_q;
  logic             last_cycle;

  assign last_cycle = (cnt_q == h_q - 1'b1);
  assign tick_o     = run_i && last_cycle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_q   <= DIV_W'(1);
      cnt_q <= '0;
    end else if (launch_i) begin
      h_q   <= DIV_W'(half_cycles(32'(div_i)));
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= last_cycle ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  // R7: the phase counter never runs past the latched half-period
  assert_count_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < h_q));
  assert_len_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    h_q != '0);

endmodule

// File: rtl/busrec_walker.sv
module busrec_walker #(
  parameter int DUMMY_CLOCKS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch_i,
  input  logic                tick_i,
  output busrec_pkg::phase_t  phase_o,
  output logic                finish_o,
  output logic                done_o
);
  import busrec_pkg::*;

  localparam int PW = $clog2(DUMMY_CLOCKS + 1);

  phase_t        phase_q, phase_d;
  logic [PW-1:0] pulses_q;
  logic          last_pulse;
  logic          done_q;

  assign last_pulse = (pulses_q == PW'(DUMMY_CLOCKS));
  assign finish_o   = (phase_q == PH_CLOSE) && tick_i;
  assign phase_o    = phase_q;
  assign done_o     = done_q;

  always_comb begin
    phase_d = phase_q;
    if (phase_q == PH_IDLE) begin
      if (launch_i) phase_d = PH_PRE;
    end else if (tick_i) begin
      case (phase_q)
        PH_PRE:         phase_d = PH_OPEN;
        PH_OPEN:        phase_d = PH_OPEN_HOLD;
        PH_OPEN_HOLD:   phase_d = PH_DUMMY_LO;
        PH_DUMMY_LO:    phase_d = PH_DUMMY_HI;
        PH_DUMMY_HI:    phase_d = last_pulse ? PH_REOPEN : PH_DUMMY_LO;
        PH_REOPEN:      phase_d = PH_REOPEN_HOLD;
        PH_REOPEN_HOLD: phase_d = PH_CLOSE_SU;
        PH_CLOSE_SU:    phase_d = PH_CLOSE;
        default:        phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      pulses_q <= '0;
      done_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= finish_o;
      if (launch_i && phase_q == PH_IDLE)
        pulses_q <= '0;
      else if (tick_i && phase_q == PH_DUMMY_LO)
        pulses_q <= pulses_q + 1'b1;
    end
  end

  // R4: never more dummy pulses than configured
  assert_pulse_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulses_q <= PW'(DUMMY_CLOCKS));
  // R5: the second start only follows the last dummy pulse
  assert_restart_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_REOPEN) |-> last_pulse);
  // R3: the first low clock half comes only from the opening hold
  assert_open_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DUMMY_LO && pulses_q == '0) |->
      ($past(phase_q) == PH_OPEN_HOLD || $past(phase_q) == PH_DUMMY_LO));
  // R11: a running sequence is never thrown back to its first phase
  assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_q) != PH_IDLE && phase_q == PH_PRE) |-> $past(phase_q) == PH_PRE);

endmodule

// File: rtl/busrec_pins.sv
module busrec_pins (
  input  logic               clk,
  input  logic               rst_n,
  input  busrec_pkg::phase_t phase_i,
  input  logic               launch_i,
  input  logic               finish_i,
  input  logic               sda_in_i,
  output logic               scl_pull_o,
  output logic               sda_pull_o,
  output logic               wp_o,
  output logic               stuck_o
);
  import busrec_pkg::*;

  lines_t lv;
  logic   wp_q;
  logic   stuck_q;

  assign lv         = phase_lines(phase_i);
  assign scl_pull_o = ~lv.scl_up;
  assign sda_pull_o = ~lv.sda_up;
  assign wp_o       = wp_q;
  assign stuck_o    = stuck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q    <= 1'b0;
      stuck_q <= 1'b0;
    end else if (launch_i) begin
      wp_q    <= 1'b1;
      stuck_q <= 1'b0;
    end else if (finish_i) begin
      wp_q    <= 1'b0;
      stuck_q <= ~sda_in_i;
    end
  end

  // R6: SDA enable moves only while SCL enable holds its level
  assert_sda_moves_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> $stable(scl_pull_o));

endmodule

// File: rtl/bus_unjam_seq.sv
module bus_unjam_seq #(
  parameter int   DIV_W        = 8,
  parameter int   DUMMY_CLOCKS = 9,
  parameter logic AUTO_START   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic             sda_in_i,
  output logic             scl_pull_o,
  output logic             sda_pull_o,
  output logic             wp_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             stuck_o
);
  import busrec_pkg::*;

  phase_t phase;
  logic   idle;
  logic   launch;
  logic   tick;
  logic   finish;
  logic   pend_q;

  assign idle   = (phase == PH_IDLE);
  assign launch = idle && (kick_i || pend_q);
  assign busy_o = !idle;

  // power-on launch request, consumed by the first run
  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= AUTO_START;
    else if (launch) pend_q <= 1'b0;
  end

  busrec_pacer #(.DIV_W(DIV_W)) u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (launch),
    .run_i    (busy_o),
    .div_i    (half_div_i),
    .tick_o   (tick)
  );

  busrec_walker #(.DUMMY_CLOCKS(DUMMY_CLOCKS)) u_walker (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (launch),
    .tick_i   (tick),
    .phase_o  (phase),
    .finish_o (finish),
    .done_o   (done_o)
  );

  busrec_pins u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_i    (phase),
    .launch_i   (launch),
    .finish_i   (finish),
    .sda_in_i   (sda_in_i),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o),
    .wp_o       (wp_o),
    .stuck_o    (stuck_o)
  );

  // R2: a launch always starts a run
  assert_launch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy_o);
  // R8: write-protect covers every busy cycle
  assert_wp_covers_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> wp_o);
  // R9: done marks the first idle cycle after a run
  assert_done_after_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: tb/test_bus_unjam_seq.sv
module test_bus_unjam_seq;
  localparam int DW    = 4;
  localparam int NP    = 9;
  localparam int SLOTS = 2 * NP + 7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          kick  = 1'b0;
  logic [DW-1:0] div   = DW'(2);
  logic          sda_in;
  logic          scl_pull, sda_pull, wp, busy, done, stuck;

  int checks = 0;
  int fails  = 0;

  // slave model: holds SDA low until it has seen hold_target SCL rises
  logic arm       = 1'b0;
  int   hold_target = 0;
  logic held      = 1'b0;
  int   rises     = 0;
  logic scl_prev  = 1'b1;

  assign sda_in = ~(sda_pull | held);

  always @(posedge clk) begin
    scl_prev <= ~scl_pull;
    if (arm) begin
      held  <= (hold_target > 0);
      rises <= 0;
    end else if (held && !scl_pull && !scl_prev) begin
      rises <= rises + 1;
      if (rises + 1 >= hold_target) held <= 1'b0;
    end
  end

  bus_unjam_seq #(.DIV_W(DW), .DUMMY_CLOCKS(NP), .AUTO_START(1'b1)) i_bus_unjam_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .kick_i     (kick),
    .half_div_i (div),
    .sda_in_i   (sda_in),
    .scl_pull_o (scl_pull),
    .sda_pull_o (sda_pull),
    .wp_o       (wp),
    .busy_o     (busy),
    .done_o     (done),
    .stuck_o    (stuck)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected {scl_up, sda_up} in cycle c of a run with half-period h
  function automatic logic [1:0] exp_lvl(input int c, input int h);
    int s = c / h;
    if (s == 0)                        return 2'b11;
    if (s == 1)                        return 2'b10;
    if (s == 2)                        return 2'b00;
    if (s < 3 + 2 * NP)                return ((s - 3) % 2 == 0) ? 2'b01 : 2'b11;
    if (s == 2 * NP + 3)               return 2'b10;
    if (s == 2 * NP + 4)               return 2'b00;
    if (s == 2 * NP + 5)               return 2'b10;
    return 2'b11;
  endfunction

  // called at the negedge right after the launching edge
  task automatic watch_run(input int d, input int hold, input int kick_at);
    int h = (d == 0) ? 1 : d;
    int starts = 0;
    int srise  = 0;
    int first_sda_low = -1;
    int first_scl_low = -1;
    logic [1:0] prev = 2'b11;
    logic [1:0] lv;
    for (int c = 0; c < SLOTS * h; c++) begin
      if (kick_at >= 0) kick = (c == kick_at);
      lv = {~scl_pull, ~sda_pull};
      chk(lv == exp_lvl(c, h), "R7", "line levels", int'(lv), int'(exp_lvl(c, h)));
      chk(busy == 1'b1, "R2", "busy in run", int'(busy), 1);
      chk(wp == 1'b1, "R8", "write-protect in run", int'(wp), 1);
      chk(done == 1'b0, "R9", "done in run", int'(done), 0);
      if (lv[1] && prev[1] && prev[0] && !lv[0]) starts++;
      if (lv[1] && !prev[1]) srise++;
      if (!lv[0] && first_sda_low < 0) first_sda_low = c;
      if (!lv[1] && first_scl_low < 0) first_scl_low = c;
      prev = lv;
      @(negedge clk);
    end
    kick = 1'b0;
    chk(first_sda_low == h && first_scl_low > first_sda_low, "R3", "opening start order",
        first_scl_low, 2 * h);
    chk(srise == NP + 1, "R4", "SCL rises (dummies plus stop setup)", srise, NP + 1);
    chk(starts == 2, "R5", "start conditions", starts, 2);
    chk(busy == 1'b0, "R2", "busy after run", int'(busy), 0);
    chk(done == 1'b1, "R9", "done pulse", int'(done), 1);
    chk(scl_pull == 1'b0 && sda_pull == 1'b0, "R6", "lines released at end",
        int'({scl_pull, sda_pull}), 0);
    chk(stuck == (hold > NP + 1), "R10", "stuck flag", int'(stuck), int'(hold > NP + 1));
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", int'(done), 0);
    for (int k = 0; k < 4; k++) begin
      chk(busy == 1'b0, "R11", "no second run", int'(busy), 0);
      chk(stuck == (hold > NP + 1), "R10", "stuck held", int'(stuck), int'(hold > NP + 1));
      @(negedge clk);
    end
  endtask

  task automatic kick_run(input int d, input int hold, input int kick_at);
    div = DW'(d);
    hold_target = hold;
    kick = 1'b1;
    arm  = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    arm  = 1'b0;
    watch_run(d, hold, kick_at);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL R2 watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    hold_target = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(scl_pull == 1'b0 && sda_pull == 1'b0, "R1", "pulls in reset",
        int'({scl_pull, sda_pull}), 0);
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", int'({busy, done}), 0);
    chk(wp == 1'b0 && stuck == 1'b0, "R1", "wp/stuck in reset", int'({wp, stuck}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: automatic run after reset without a request
    chk(busy == 1'b1, "R12", "auto launch", int'(busy), 1);
    watch_run(2, 0, -1);
    // R7: divider sweep including zero
    for (int d = 0; d <= 4; d++) kick_run(d, 0, -1);
    // R10: slave released at different points
    kick_run(2, 3, -1);
    kick_run(2, 9, -1);
    kick_run(2, 10, -1);
    kick_run(2, 11, -1);
    kick_run(1, 15, -1);
    // R10: clean run after a stuck one clears the flag
    kick_run(2, 0, -1);
    // R11: requests during a run
    kick_run(3, 0, 5);
    kick_run(1, 0, 10);
    kick_run(2, 0, 49);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule